// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Optional Ninth Data Bit

This block turns bytes written by a host into asynchronous serial frames on a single output line. The host first reads the status port to see that the transmitter-empty flag is set, then writes a byte into a write-only holding buffer. When the line is free, the block moves the held byte into an 11-bit shift register. It frames the byte with a low start bit and a high stop bit and shifts it out least significant bit first. Each bit lasts one period of an external bit-rate enable pulse. A length select adds a ninth data bit taken from a separate input. The bit just before the stop bit is always sent as data.

Transmission needs both a global enable and a transmitter enable. After the pair becomes active, the first thing on the line is a warm-up frame of all ones. Only then does the first held byte go out. The empty flag sets again as soon as the held byte moves into the shift register, so the host can queue the next byte while the current one is on the line. Frames then follow with no idle gap.

The control is a three-state machine. ST_IDLE holds the line high. ST_PREAMBLE shifts the warm-up ones. ST_FRAME shifts a data frame. Its transitions are:
- warm-up: ST_IDLE to ST_PREAMBLE, on a bit pulse while enabled and not yet warmed up.
- launch: ST_IDLE to ST_FRAME, on a bit pulse while enabled, warmed up and the buffer is full.
- first-load: ST_PREAMBLE to ST_FRAME, on the last warm-up bit while enabled and the buffer is full.
- chain: ST_FRAME to ST_FRAME, on the last bit while enabled and the buffer is full.
- settle: ST_PREAMBLE or ST_FRAME to ST_IDLE, on the last bit otherwise.

Top module: `uart9_tx`

## Requirements
- R1: After reset the serial output `txd` is 1 and `tx_empty` is 1.
- R2: A buffer write clears `tx_empty` and stores the byte only if a status read was seen while `tx_empty` was 1 earlier than the write. A write without such a read is ignored: the flag stays 1 and the byte is never sent.
- R3: A status read made while `tx_empty` is 0 does not enable a later write. Once the buffer drains, a write with no fresh read is ignored.
- R4: No frame starts unless `sys_en` and `tx_en` are both 1. While no frame is in progress, `txd` is 1.
- R5: When the enables become active, the first bit pulse starts a warm-up of all ones lasting 10 bit periods when `len9`=0, or 11 when `len9`=1. A held byte therefore starts on the 11th bit pulse (or the 12th) after enabling.
- R6: With `len9`=0 a frame is, in time order: 0, data bits 0 through 7, then 1.
- R7: With `len9`=1 a frame is, in time order: 0, data bits 0 through 7, the `bit8_in` value, then 1.
- R8: `tx_empty` returns to 1 on the bit pulse where the held byte enters the shift register. A byte written during a frame starts on the pulse that ends the previous stop bit, with no idle bit between.
- R9: `txd` changes only on a clock edge where `bit_tick` is 1, so each bit lasts exactly one bit-pulse period.
- R10: Clearing `tx_en` during a frame lets that frame complete unchanged. After it the line stays 1 and a newly held byte is not sent.
- R11: `len9` and `bit8_in` are sampled when a byte loads. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_en | input | 1 | Global block enable |
| tx_en | input | 1 | Transmitter enable |
| len9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| bit8_in | input | 1 | Ninth data bit used in 9-bit frames |
| bit_tick | input | 1 | One-cycle bit-rate enable pulse |
| wr_stb | input | 1 | Host write strobe to the holding buffer |
| wr_data | input | DATA_W | Byte written by the host |
| stat_rd | input | 1 | Host status read strobe |
| tx_empty | output | 1 | Transmitter-empty status flag |
| txd | output | 1 | Serial output, idle high |

## Verification
Flag results are due in the cycle after the strobe. `tx_empty` falls on the edge that takes the write, and it rises on the bit-pulse edge that launches a frame. The bench reads these at the following falling clock edge. Line bits change only on bit-pulse edges. The bench finds the falling edge of the start bit at a falling clock edge and then samples every bit half a bit period later, at eight-cycle spacing, so no sample lands near a bit boundary. Warm-up length is measured by counting bit pulses from enabling to the start bit, expected 11 or 12. Bit width is measured as the number of clocks between line transitions, expected 8.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_FRAME    = 2'd2
    } tx_state_e;

endpackage

// File: rtl/uart9_txbuf.sv
module uart9_txbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_rd,
    input  logic              take,
    output logic [DATA_W-1:0] hold_q,
    output logic              full_q
);
    logic armed_q;
    logic accept;

    assign accept = wr_stb && armed_q && !full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            full_q  <= 1'b0;
            hold_q  <= '0;
        end else begin
            if (accept) begin
                hold_q  <= wr_data;
                full_q  <= 1'b1;
                armed_q <= 1'b0;
            end else begin
                if (take)
                    full_q <= 1'b0;
                if (stat_rd && !full_q)
                    armed_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart9_txshift.sv
module uart9_txshift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_pre,
    input  logic              load_chr,
    input  logic              shift,
    input  logic              len9,
    input  logic              bit8,
    input  logic [DATA_W-1:0] data,
    output logic              sdo,
    output logic              last
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   len_bits;
    logic [FRAME_W-1:0] chr_img;

    assign len_bits = len9 ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
    assign chr_img  = len9 ? {1'b1, bit8, data, 1'b0} : {2'b11, data, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '1;
            cnt_q  <= '0;
        end else if (load_pre) begin
            sreg_q <= '1;
            cnt_q  <= len_bits;
        end else if (load_chr) begin
            sreg_q <= chr_img;
            cnt_q  <= len_bits;
        end else if (shift) begin
            sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign sdo  = sreg_q[0];
    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/uart9_txfsm.sv
module uart9_txfsm
    import uart9_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_tick,
    input  logic full,
    input  logic last,
    output logic load_pre,
    output logic load_chr,
    output logic shift,
    output logic take,
    output logic busy
);
    tx_state_e state_q, state_d;
    logic      primed_q;
    logic      pre_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            primed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!en)
                primed_q <= 1'b0;
            else if (pre_done)
                primed_q <= 1'b1;
        end
    end

    always_comb begin
        state_d  = state_q;
        load_pre = 1'b0;
        load_chr = 1'b0;
        shift    = 1'b0;
        pre_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_tick && en) begin
                    if (!primed_q) begin
                        state_d  = ST_PREAMBLE;
                        load_pre = 1'b1;
                    end else if (full) begin
                        state_d  = ST_FRAME;
                        load_chr = 1'b1;
                    end
                end
            end
            ST_PREAMBLE: begin
                if (bit_tick) begin
                    if (last) begin
                        pre_done = 1'b1;
                        if (en && full) begin
                            state_d  = ST_FRAME;
                            load_chr = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            ST_FRAME: begin
                if (bit_tick) begin
                    if (last) begin
                        if (en && full) begin
                            load_chr = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign take = load_chr;
    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_en,
    input  logic              tx_en,
    input  logic              len9,
    input  logic              bit8_in,
    input  logic              bit_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_rd,
    output logic              tx_empty,
    output logic              txd
);
    logic              en;
    logic              full;
    logic              take;
    logic              load_pre;
    logic              load_chr;
    logic              shift;
    logic              last;
    logic              sdo;
    logic              busy;
    logic [DATA_W-1:0] hold;

    assign en = sys_en && tx_en;

    uart9_txbuf #(.DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .stat_rd (stat_rd),
        .take    (take),
        .hold_q  (hold),
        .full_q  (full)
    );

    uart9_txshift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_pre (load_pre),
        .load_chr (load_chr),
        .shift    (shift),
        .len9     (len9),
        .bit8     (bit8_in),
        .data     (hold),
        .sdo      (sdo),
        .last     (last)
    );

    uart9_txfsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .bit_tick (bit_tick),
        .full     (full),
        .last     (last),
        .load_pre (load_pre),
        .load_chr (load_chr),
        .shift    (shift),
        .take     (take),
        .busy     (busy)
    );

    assign tx_empty = !full;
    assign txd      = busy ? sdo : 1'b1;
endmodule

// File: rtl/uart9_tx_chk.sv
module uart9_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic sys_en,
    input logic tx_en,
    input logic bit_tick,
    input logic wr_stb,
    input logic tx_empty,
    input logic txd,
    input logic busy
);
    // R4: line high whenever no frame or warm-up is active
    p_idle_line_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R4: nothing leaves idle while either enable is low
    p_no_start_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(sys_en && tx_en)) |=> !busy);

    // R9: the line moves only on bit-pulse edges
    p_txd_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));

    // R2: the flag falls only on an accepted write
    p_empty_fall_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_stb));

    // R8: the flag rises only when a bit pulse loads the shifter
    p_empty_rise_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> ($past(bit_tick) && busy));
endmodule

bind uart9_tx uart9_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_en   (sys_en),
    .tx_en    (tx_en),
    .bit_tick (bit_tick),
    .wr_stb   (wr_stb),
    .tx_empty (tx_empty),
    .txd      (txd),
    .busy     (busy)
);

// File: tb/sim_uart9_tx.sv
module sim_uart9_tx;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       len9 = 1'b0;
    logic       bit8_in = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stat_rd = 1'b0;
    logic       tx_empty;
    logic       txd;

    int errors = 0;
    int checks = 0;
    int ticks_seen = 0;
    int divc = 0;
    int det_ticks = 0;
    logic det_empty = 1'b0;
    bit done = 1'b0;

    uart9_tx #(.DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .tx_en(tx_en),
        .len9(len9), .bit8_in(bit8_in), .bit_tick(bit_tick),
        .wr_stb(wr_stb), .wr_data(wr_data), .stat_rd(stat_rd),
        .tx_empty(tx_empty), .txd(txd)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        divc     <= (divc == DIV - 1) ? 0 : divc + 1;
        bit_tick <= (divc == DIV - 1);
    end

    always @(posedge clk) if (bit_tick) ticks_seen <= ticks_seen + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [21:0] frm(input logic [7:0] d, input bit l9, input bit b8);
        return l9 ? {11'h7FF, 1'b1, b8, d, 1'b0} : {12'hFFF, 1'b1, d, 1'b0};
    endfunction

    task automatic host_read();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic host_wr_only(input logic [7:0] d);
        @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        host_read();
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk) wr_stb = 1'b0;
    endtask

    // act_kind: 0 none, 1 drop tx_en, 2 swap len9/bit8, 3 queue next byte
    task automatic capture(input int n, input int act_at, input int act_kind,
                           input logic [7:0] nxt, output logic [21:0] bits);
        int t0;
        int guard;
        t0 = ticks_seen;
        guard = 0;
        bits = '1;
        while (txd !== 1'b0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 3000) begin
            chk(1'b0, "R6", "start bit timeout", 0, 1);
            return;
        end
        det_ticks = ticks_seen - t0;
        det_empty = tx_empty;
        repeat (DIV / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i > 0) repeat (DIV) @(negedge clk);
            bits[i] = txd;
            if (i == act_at) begin
                case (act_kind)
                    1: tx_en = 1'b0;
                    2: begin len9 = ~len9; bit8_in = ~bit8_in; end
                    3: fork host_write(nxt); join_none
                    default: ;
                endcase
            end
        end
    endtask

    task automatic line_quiet(input int periods, input string req);
        bit ok = 1'b1;
        repeat (periods * DIV) begin
            @(negedge clk);
            if (txd !== 1'b1) ok = 1'b0;
        end
        chk(ok, req, "line stays high", int'(ok), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(tx_empty === 1'b1, "R1", "empty after reset", int'(tx_empty), 1);
    endtask

    task automatic t_handshake();
        logic [21:0] b;
        host_wr_only(8'hA5);
        chk(tx_empty === 1'b1, "R2", "write without read keeps flag", int'(tx_empty), 1);
        host_write(8'h3C);
        chk(tx_empty === 1'b0, "R2", "read then write clears flag", int'(tx_empty), 0);
        host_read();
        sys_en = 1'b1;
        line_quiet(4, "R4");
        chk(tx_empty === 1'b0, "R4", "held byte not taken with tx_en=0", int'(tx_empty), 0);
        sys_en = 1'b0; tx_en = 1'b1;
        line_quiet(4, "R4");
        sys_en = 1'b1;
        capture(10, -1, 0, 8'h00, b);
        chk(det_ticks == 11, "R5", "8-bit warm-up pulses", det_ticks, 11);
        chk(b == frm(8'h3C, 1'b0, 1'b0), "R6", "8-bit frame of held byte", int'(b),
            int'(frm(8'h3C, 1'b0, 1'b0)));
        chk(det_empty === 1'b1, "R8", "flag set at load", int'(det_empty), 1);
        repeat (DIV) @(negedge clk);
        host_wr_only(8'h77);
        chk(tx_empty === 1'b1, "R3", "read while full gives no arm", int'(tx_empty), 1);
        line_quiet(3, "R3");
    endtask

    task automatic t_nine_bit();
        logic [21:0] b;
        sys_en = 1'b0; tx_en = 1'b0;
        len9 = 1'b1; bit8_in = 1'b1;
        host_write(8'h5A);
        sys_en = 1'b1; tx_en = 1'b1;
        capture(11, -1, 0, 8'h00, b);
        chk(det_ticks == 12, "R5", "9-bit warm-up pulses", det_ticks, 12);
        chk(b == frm(8'h5A, 1'b1, 1'b1), "R7", "9-bit frame bit8=1", int'(b),
            int'(frm(8'h5A, 1'b1, 1'b1)));
        repeat (DIV) @(negedge clk);
        bit8_in = 1'b0;
        host_write(8'hC3);
        capture(11, 1, 2, 8'h00, b);
        chk(b == frm(8'hC3, 1'b1, 1'b0), "R11", "format frozen at load", int'(b),
            int'(frm(8'hC3, 1'b1, 1'b0)));
        len9 = 1'b0; bit8_in = 1'b0;
        repeat (DIV) @(negedge clk);
    endtask

    task automatic t_bit_width();
        int n;
        host_write(8'h01);
        while (txd !== 1'b0) @(negedge clk);
        n = 0;
        while (txd === 1'b0 && n < 100) begin @(negedge clk); n++; end
        chk(n == DIV, "R9", "start bit width", n, DIV);
        n = 0;
        while (txd === 1'b1 && n < 100) begin @(negedge clk); n++; end
        chk(n == DIV, "R9", "data bit width", n, DIV);
        repeat (10 * DIV) @(negedge clk);
    endtask

    task automatic t_back_to_back();
        logic [21:0] b;
        host_write(8'h96);
        capture(20, 2, 3, 8'h4B, b);
        chk(det_empty === 1'b1, "R8", "flag set at first load", int'(det_empty), 1);
        chk(b == {2'b11, 1'b1, 8'h4B, 1'b0, 1'b1, 8'h96, 1'b0}, "R8",
            "chained frames no gap", int'(b),
            int'({2'b11, 1'b1, 8'h4B, 1'b0, 1'b1, 8'h96, 1'b0}));
        repeat (DIV) @(negedge clk);
    endtask

    task automatic t_disable_mid();
        logic [21:0] b;
        host_write(8'hE1);
        capture(10, 4, 1, 8'h00, b);
        chk(b == frm(8'hE1, 1'b0, 1'b0), "R10", "frame completes after tx_en drop",
            int'(b), int'(frm(8'hE1, 1'b0, 1'b0)));
        host_write(8'h11);
        line_quiet(4, "R10");
        chk(tx_empty === 1'b0, "R10", "new byte held, not sent", int'(tx_empty), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_handshake();
        t_nine_bit();
        t_bit_width();
        t_back_to_back();
        t_disable_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule